// File: doc/BRIEF.md
# Dual Privilege-Gated Event Counters

This block holds two 32-bit event counters and one 32-bit control word that steers them. For each counter the control word picks one event code, plus a set of enable bits. The current privilege level (a two-bit mode and an exception-level flag) chooses which enable bit applies. Each clock cycle the block samples a vector of per-cycle event pulses, indexed by event code. A counter advances by one in any cycle where its event pulses, its code belongs to the countable group, and the enable bit for the current privilege level is set.

Software reaches the control word and both counters through a single access port. The target is chosen by a six-bit immediate. Reads are combinational and sign-extended to 64 bits. A counter read already includes the increment being added in the same cycle. Each counter also has a sticky overflow flag. The block only raises this flag; it does not take any exception.

Top module: `perf_dual_counter`

## Requirements
- R1: After reset, both counters, both overflow flags and the control word are zero, so a read with immediate 0 returns zero.
- R2: Counter 0 advances by exactly 1 on the clock edge after a cycle where all three hold: its event pulse `evt_i[ctrl[9:5]]` is high, that code is countable, and either ctrl bit (2+mode) is set with mode 0..2, or `exl_i` is high and ctrl bit 1 is set. Mode 3 enables nothing through the mode bits.
- R3: Counter 1 follows the same rule, using event field ctrl[19:15], mode bits ctrl bit (12+mode) and exception bit ctrl bit 11.
- R4: Only event codes 1, 2, 3, 12, 13, 14 and 15 are countable. Codes 0, 4 through 11 and 16 through 31 never advance a counter.
- R5: A counter's overflow flag is set when an increment leaves the counter's bit 31 at one, and it then stays set while the counter only counts. A load sets the flag to bit 31 of the loaded value.
- R6: A write with immediate bit 0 clear updates the control word on the next edge only when immediate bits 5:1 are all zero. Any other such write leaves the control word unchanged.
- R7: A write with immediate bit 0 set loads counter 0 when bit 1 is clear and counter 1 when bit 1 is set, on the next edge. Any increment from that cycle is discarded, and the other counter is unaffected.
- R8: In the cycle of a control write, both counters still advance under the old control word. The new word governs from the following cycle.
- R9: The read data is the control word when immediate bit 0 is clear. Otherwise it is the selected counter plus its same-cycle increment. Either value is sign-extended from bit 31 to 64 bits.
- R10: A counter holding 0xFFFFFFFF that advances wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | 32 | Per-cycle event pulses, bit n for event code n |
| ksu_i | input | 2 | Current privilege mode (0..2 valid) |
| exl_i | input | 1 | Exception-level flag |
| acc_we_i | input | 1 | Write strobe of the access port |
| acc_imm_i | input | 6 | Immediate selecting control word or counter |
| acc_wdata_i | input | 32 | Write data |
| acc_rdata_o | output | 64 | Sign-extended read data (combinational) |
| cnt0_o | output | 32 | Counter 0 value |
| cnt1_o | output | 32 | Counter 1 value |
| ovf_o | output | 2 | Sticky overflow flags, bit i for counter i |

## Verification
Counter values, overflow flags and control writes take effect one clock edge after the cycle that causes them. The read port answers in the same cycle, and its counter value already includes that cycle's increment. The bench drives every input on the falling edge and samples on the next falling edge. A sample therefore lands after exactly the edges it expects: N edges for N counted cycles, one edge for a load or control write. A control write made while events keep firing is checked at both the first and the second edge, which separates the folded increment from the new control's effect.

// File: rtl/perf_pkg.sv
package perf_pkg;
  localparam int CNT_W     = 32;
  localparam int CTRL_W    = 32;
  localparam int SEL_W     = 5;
  localparam int NUM_EVT   = 1 << SEL_W;
  localparam int XLEN      = 64;
  localparam int IMM_W     = 6;
  localparam int NUM_CNT   = 2;
  localparam int MODE_NUM  = 3;
  // per-counter layout of the control word, counter i is shifted by STRIDE*i
  localparam int STRIDE    = 10;
  localparam int EXL_BASE  = 1;
  localparam int MODE_BASE = 2;
  localparam int SEL_BASE  = 5;

  function automatic logic is_countable(input logic [SEL_W-1:0] code);
    return code inside {5'd1, 5'd2, 5'd3, 5'd12, 5'd13, 5'd14, 5'd15};
  endfunction
endpackage

// File: rtl/perf_enable.sv
module perf_enable
  import perf_pkg::*;
#(
  parameter int SW = SEL_W,
  parameter int NE = NUM_EVT
) (
  input  logic [SW-1:0]       sel_i,
  input  logic [MODE_NUM-1:0] mode_en_i,
  input  logic                exl_en_i,
  input  logic [1:0]          ksu_i,
  input  logic                exl_i,
  input  logic [NE-1:0]       evt_i,
  output logic                hit_o
);
  logic mode_ok;
  logic level_ok;

  always_comb begin
    case (ksu_i)
      2'd0:    mode_ok = mode_en_i[0];
      2'd1:    mode_ok = mode_en_i[1];
      2'd2:    mode_ok = mode_en_i[2];
      default: mode_ok = 1'b0;
    endcase
    level_ok = mode_ok | (exl_i & exl_en_i);
    hit_o    = level_ok & is_countable(sel_i) & evt_i[sel_i];
  end
endmodule

// File: rtl/perf_cnt.sv
module perf_cnt #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hit_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] count_o,
  output logic [W-1:0] peek_o,
  output logic         ovf_o
);
  logic [W-1:0] count_q, count_d, sum;
  logic         ovf_q, ovf_d, upd;

  always_comb begin
    sum     = count_q + {{(W-1){1'b0}}, hit_i};
    upd     = hit_i | load_i;
    count_d = load_i ? load_val_i : sum;
    ovf_d   = load_i ? load_val_i[W-1] : (ovf_q | sum[W-1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else if (upd) begin
      count_q <= count_d;
      ovf_q   <= ovf_d;
    end
  end

  assign count_o = count_q;
  assign peek_o  = sum;
  assign ovf_o   = ovf_q;

  // R2: one increment per hit cycle
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i && !load_i) |=> (count_q == $past(count_q) + W'(1)));
  // R4: no hit, no load, no change
  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_i && !load_i) |=> $stable(count_q));
  // R7: a load wins over the increment
  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (count_q == $past(load_val_i)));
  // R5: flag is sticky while only counting
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !load_i) |=> ovf_o);
  // R5: crossing into bit 31 raises the flag
  p_raise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i && !load_i && count_q == {1'b0, {(W-1){1'b1}}}) |=> ovf_o);
endmodule

// File: rtl/perf_dual_counter.sv
module perf_dual_counter
  import perf_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int XW = XLEN
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [1:0]         ksu_i,
  input  logic               exl_i,
  input  logic               acc_we_i,
  input  logic [IMM_W-1:0]   acc_imm_i,
  input  logic [CTRL_W-1:0]  acc_wdata_i,
  output logic [XW-1:0]      acc_rdata_o,
  output logic [CW-1:0]      cnt0_o,
  output logic [CW-1:0]      cnt1_o,
  output logic [NUM_CNT-1:0] ovf_o
);
  localparam int EXT_W = XW - CW;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              ctrl_we;
  logic              sel_ctrl;
  logic [CW-1:0]     count [NUM_CNT];
  logic [CW-1:0]     peek  [NUM_CNT];
  logic [CW-1:0]     rd_word;

  // reset: asserted asynchronously, released after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // control word: next state and register
  always_comb begin
    sel_ctrl = ~acc_imm_i[0];
    ctrl_we  = acc_we_i & sel_ctrl & (acc_imm_i[IMM_W-1:1] == '0);
    ctrl_d   = acc_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_d;
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    localparam int MODE_LSB = MODE_BASE + STRIDE * i;
    localparam int EXL_BIT  = EXL_BASE + STRIDE * i;
    localparam int SEL_LSB  = SEL_BASE + STRIDE * i;
    logic hit;
    logic load;

    assign load = acc_we_i & acc_imm_i[0] & (acc_imm_i[1] == i[0]);

    perf_enable u_en (
      .sel_i     (ctrl_q[SEL_LSB +: SEL_W]),
      .mode_en_i (ctrl_q[MODE_LSB +: MODE_NUM]),
      .exl_en_i  (ctrl_q[EXL_BIT]),
      .ksu_i     (ksu_i),
      .exl_i     (exl_i),
      .evt_i     (evt_i),
      .hit_o     (hit)
    );

    perf_cnt #(.W(CW)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .hit_i      (hit),
      .load_i     (load),
      .load_val_i (acc_wdata_i[CW-1:0]),
      .count_o    (count[i]),
      .peek_o     (peek[i]),
      .ovf_o      (ovf_o[i])
    );
  end

  // read path: combinational, counters include this cycle's increment
  always_comb begin
    rd_word     = sel_ctrl ? ctrl_q[CW-1:0] : peek[acc_imm_i[1]];
    acc_rdata_o = {{EXT_W{rd_word[CW-1]}}, rd_word};
  end

  assign cnt0_o = count[0];
  assign cnt1_o = count[1];

  // R6: writes with a nonzero field in bits 5:1 leave the control word alone
  p_ctrl_ignore_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc_we_i && !acc_imm_i[0] && (acc_imm_i[IMM_W-1:1] != '0)) |=> $stable(ctrl_q));
  // R6: accepted writes appear on the next edge
  p_ctrl_take_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc_we_i && acc_imm_i == '0) |=> (ctrl_q == $past(acc_wdata_i)));
  // R7: a load of one counter leaves the other counter's load path idle
  p_one_load_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({g_cnt[1].load, g_cnt[0].load}));
endmodule

// File: tb/perf_dual_counter_test.sv
`timescale 1ns/1ps
module perf_dual_counter_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] evt;
  logic [1:0]  ksu;
  logic        exl;
  logic        we;
  logic [5:0]  imm;
  logic [31:0] wdata;
  logic [63:0] rdata;
  logic [31:0] cnt0, cnt1;
  logic [1:0]  ovf;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  perf_dual_counter uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .ksu_i(ksu), .exl_i(exl),
    .acc_we_i(we), .acc_imm_i(imm), .acc_wdata_i(wdata),
    .acc_rdata_o(rdata), .cnt0_o(cnt0), .cnt1_o(cnt1), .ovf_o(ovf)
  );

  typedef struct packed {
    logic [4:0]  sel0;
    logic [2:0]  m0;
    logic        x0;
    logic [4:0]  sel1;
    logic [2:0]  m1;
    logic        x1;
    logic [1:0]  ksu;
    logic        exl;
    logic [31:0] evt;
    logic        e0;
    logic        e1;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{5'd1,  3'b001, 1'b0, 5'd2,  3'b001, 1'b0, 2'd0, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b1},
    '{5'd1,  3'b001, 1'b0, 5'd3,  3'b010, 1'b0, 2'd1, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b1},
    '{5'd12, 3'b100, 1'b0, 5'd15, 3'b000, 1'b1, 2'd2, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b1},
    '{5'd12, 3'b000, 1'b0, 5'd15, 3'b000, 1'b0, 2'd2, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0},
    '{5'd4,  3'b111, 1'b1, 5'd11, 3'b111, 1'b1, 2'd0, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0},
    '{5'd0,  3'b111, 1'b1, 5'd16, 3'b111, 1'b1, 2'd0, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0},
    '{5'd2,  3'b111, 1'b0, 5'd13, 3'b111, 1'b0, 2'd1, 1'b0, 32'h0000_2000, 1'b0, 1'b1},
    '{5'd1,  3'b111, 1'b0, 5'd1,  3'b111, 1'b0, 2'd3, 1'b0, 32'hFFFF_FFFF, 1'b0, 1'b0},
    '{5'd1,  3'b000, 1'b1, 5'd1,  3'b111, 1'b0, 2'd3, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b0},
    '{5'd14, 3'b010, 1'b0, 5'd7,  3'b010, 1'b0, 2'd1, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b0}
  };

  function automatic logic [31:0] mk_ctrl(input vec_t v);
    return {12'd0, v.sel1, v.m1, v.x1, 1'b0, v.sel0, v.m0, v.x0, 1'b0};
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] i, input logic [31:0] d);
    we = 1'b1; imm = i; wdata = d;
    tick();
    we = 1'b0; imm = 6'd0; wdata = 32'd0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] last_ctrl;
    last_ctrl = 32'd0;
    rst_n = 1'b0; evt = '0; ksu = '0; exl = 1'b0;
    we = 1'b0; imm = '0; wdata = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R1 reset state
    chk("R1 cnt0", {32'd0, cnt0}, 64'd0);
    chk("R1 cnt1", {32'd0, cnt1}, 64'd0);
    chk("R1 ovf", {62'd0, ovf}, 64'd0);
    chk("R1 ctrl read", rdata, 64'd0);

    // R2 R3 R4: table of privilege/event patterns, four counting cycles each
    for (int k = 0; k < NV; k++) begin
      evt = '0;
      last_ctrl = mk_ctrl(VEC[k]);
      wr(6'b000000, last_ctrl);
      wr(6'b000001, 32'd0);
      wr(6'b000011, 32'd0);
      ksu = VEC[k].ksu; exl = VEC[k].exl; evt = VEC[k].evt;
      repeat (4) tick();
      evt = '0;
      chk($sformatf("R2 R4 row %0d cnt0", k), {32'd0, cnt0}, {61'd0, VEC[k].e0, 2'b00});
      chk($sformatf("R3 R4 row %0d cnt1", k), {32'd0, cnt1}, {61'd0, VEC[k].e1, 2'b00});
    end

    // R6: writes with nonzero bits 5:1 are ignored
    ksu = 2'd0; exl = 1'b0;
    wr(6'b000010, 32'hFFFF_FFFF);
    wr(6'b100000, 32'hFFFF_FFFF);
    imm = 6'd0;
    chk("R6 ignored write", rdata, {32'd0, last_ctrl});

    // R9: control read sign-extended; counter 0 enabled in mode 0 on code 1
    wr(6'b000000, 32'h8000_0024);
    chk("R9 ctrl sext", rdata, 64'hFFFF_FFFF_8000_0024);

    // R5 R9: crossing into bit 31
    wr(6'b000001, 32'h7FFF_FFFE);
    chk("R7 load cnt0", {32'd0, cnt0}, 64'h7FFF_FFFE);
    chk("R5 flag clear", {62'd0, ovf}, 64'd0);
    evt = '1; imm = 6'b000001;
    tick();
    chk("R9 read with increment", rdata, 64'hFFFF_FFFF_8000_0000);
    chk("R5 flag before cross", {63'd0, ovf[0]}, 64'd0);
    tick();
    chk("R5 cnt0 crossed", {32'd0, cnt0}, 64'h8000_0000);
    chk("R5 flag raised", {63'd0, ovf[0]}, 64'd1);
    evt = '0; imm = 6'd0;
    repeat (2) tick();
    chk("R5 flag sticky", {63'd0, ovf[0]}, 64'd1);
    chk("R4 no event holds", {32'd0, cnt0}, 64'h8000_0000);

    // R10 wrap, R5 load sets flag from bit 31
    wr(6'b000001, 32'hFFFF_FFFF);
    evt = '1;
    tick();
    evt = '0;
    chk("R10 wrap", {32'd0, cnt0}, 64'd0);
    chk("R5 flag kept after wrap", {63'd0, ovf[0]}, 64'd1);
    wr(6'b000001, 32'd5);
    chk("R5 load clears flag", {63'd0, ovf[0]}, 64'd0);

    // R7: load drops the same-cycle increment, other counter keeps counting
    wr(6'b000000, 32'h0001_1024);
    wr(6'b000011, 32'd0);
    evt = '1;
    we = 1'b1; imm = 6'b000011; wdata = 32'd100;
    tick();
    we = 1'b0; imm = 6'd0; wdata = 32'd0;
    chk("R7 load cnt1 drops increment", {32'd0, cnt1}, 64'd100);
    chk("R7 cnt0 unaffected", {32'd0, cnt0}, 64'd6);
    tick();
    chk("R7 cnt1 resumes", {32'd0, cnt1}, 64'd101);

    // R8: control write with events active folds the old-control count
    wr(6'b000000, 32'd0);
    chk("R8 cnt0 folded", {32'd0, cnt0}, 64'd8);
    chk("R8 cnt1 folded", {32'd0, cnt1}, 64'd102);
    tick();
    chk("R8 cnt0 stopped", {32'd0, cnt0}, 64'd8);
    chk("R8 cnt1 stopped", {32'd0, cnt1}, 64'd102);
    evt = '0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule